// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block keeps the settings that a clock synthesizer's dividers run from: a 9-bit feedback divide value, a 2-bit output divide code and a 2-bit test-select code. The values can be set in two ways. The first is a parallel path, where static pins are tracked while a capture strobe is low and are frozen when the strobe rises. The second is a serial path, where a 14-slot frame is clocked into a shift register and a transfer strobe moves it to the active values.

All control pins are asynchronous to the system clock. Each one passes through a two-stage synchronizer, and its edges are detected in the system clock domain. A single TEST status pin is driven from one of four sources. The serially loaded select code picks the source. The pin stays low whenever the active values belong to the parallel path. A divider-clear input masks the two clock taps on TEST and leaves every stored value untouched.

Top module: `synth_cfg_port`

## Requirements
- R1: While `par_hold` is low, `act_m` and `act_n` follow `par_m` and `par_n`.
- R2: When `par_hold` rises, the pin values are captured, and later pin changes do not reach `act_m`/`act_n` while `par_hold` stays high and no serial transfer occurs.
- R3: When `par_hold` goes low again, the outputs return to following the pins.
- R4: While `par_hold` is high, each rising `ser_clk` shifts `ser_din` into the frame register. The frame is sent first bit first as: select code bit 1, select code bit 0, one ignored slot, divide code bit 1, divide code bit 0, then the feedback value bit 8 down to bit 0. After 14 clocks, feedback bit 0 is the most recent bit.
- R5: A rising `ser_xfer` makes `act_m`, `act_n` and `act_t` show the frame register. While `ser_xfer` stays high, every further serial clock updates them live.
- R6: A falling `ser_xfer` latches the frame into the active values. Later serial clocks change only the frame register.
- R7: A serial transfer replaces values that an earlier parallel capture set.
- R8: `act_t` selects TEST as follows: 00 gives low, 01 gives the most recently shifted serial bit, 10 gives `tap_fb`, and 11 gives `tap_out`.
- R9: TEST is low whenever the active values came from the parallel path, whatever `act_t` holds.
- R10: `div_clear` does not alter `act_m`, `act_n` or `act_t`. While it is high, selects 10 and 11 give a low TEST.
- R11: After reset, `act_t` is 00 and `act_m`/`act_n` come from the pins. If `par_hold` is high at release, the pins are captured.
- R12: Serial clocks while `par_hold` is low leave the frame register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_hold | input | 1 | Parallel capture strobe (low = follow pins) |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide code |
| ser_din | input | 1 | Serial frame data |
| ser_clk | input | 1 | Serial shift clock |
| ser_xfer | input | 1 | Serial transfer strobe |
| div_clear | input | 1 | Divider clear; masks the clock taps on TEST |
| tap_fb | input | 1 | Feedback divider output tap |
| tap_out | input | 1 | Synthesized output clock tap |
| act_m | output | 9 | Active feedback divide value |
| act_n | output | 2 | Active output divide code |
| act_t | output | 2 | Active TEST select code |
| test_o | output | 1 | Multiplexed TEST status |

## Verification
The bench sweeps all 512 feedback values through capture, ignored pin changes and release. A design that kept tracking the pins after capture, or failed to resume tracking, would be caught on the first value. Serial frames carry a random ignored-slot bit and extra clocks both during the transfer strobe and after it. A design that mis-ordered the frame, decoded the ignored slot, froze too early or kept updating after the fall would show wrong fields. It also checks that a stale select code of 11 does not reach TEST in parallel mode, that clear masks only the taps, and that clocks during parallel mode leave the frame alone.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int T_W = 2;

  typedef enum logic [1:0] {
    MODE_PAR_LIVE = 2'd0,
    MODE_PAR_HELD = 2'd1,
    MODE_SER_LIVE = 2'd2,
    MODE_SER_HELD = 2'd3
  } cfg_mode_e;

  typedef enum logic [T_W-1:0] {
    TSEL_LOW  = 2'd0,
    TSEL_SER  = 2'd1,
    TSEL_FB   = 2'd2,
    TSEL_OUT  = 2'd3
  } test_sel_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = d;
    end else begin : g_next
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int M_W    = 9,
  parameter int N_W    = 2,
  parameter int NULL_W = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sclk_s,
  input  logic                    din_s,
  input  logic                    shift_en,
  output logic [M_W-1:0]          sr_m,
  output logic [N_W-1:0]          sr_n,
  output logic [cfg_pkg::T_W-1:0] sr_t,
  output logic                    sr_head
);
  localparam int T_W     = cfg_pkg::T_W;
  localparam int FRAME_W = T_W + NULL_W + N_W + M_W;
  localparam int N_LO    = M_W;
  localparam int T_LO    = M_W + N_W + NULL_W;

  logic               sclk_prev_q;
  logic               sclk_rise;
  logic               shift_go;
  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] sr_d;

  always_comb begin
    sclk_rise = sclk_s & ~sclk_prev_q;
    shift_go  = sclk_rise & shift_en;
    sr_d      = sr_q;
    if (shift_go) sr_d = {sr_q[FRAME_W-2:0], din_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      sr_q        <= '0;
    end else begin
      sclk_prev_q <= sclk_s;
      sr_q        <= sr_d;
    end
  end

  assign sr_m    = sr_q[M_W-1:0];
  assign sr_n    = sr_q[N_LO +: N_W];
  assign sr_t    = sr_q[T_LO +: T_W];
  assign sr_head = sr_q[0];

  // R4: a qualified serial clock edge moves every stage up by one and loads the new bit
  assert_shift_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_go |=> (sr_q[0] == $past(din_s)) &&
                 (sr_q[FRAME_W-1:1] == $past(sr_q[FRAME_W-2:0])));

  // R12: with shifting disabled the frame register holds
  assert_frame_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_q));
endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl #(
  parameter int M_W = 9,
  parameter int N_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hold_s,
  input  logic                    xfer_s,
  input  logic [M_W-1:0]          pin_m,
  input  logic [N_W-1:0]          pin_n,
  input  logic [M_W-1:0]          sr_m,
  input  logic [N_W-1:0]          sr_n,
  input  logic [cfg_pkg::T_W-1:0] sr_t,
  output logic [M_W-1:0]          act_m,
  output logic [N_W-1:0]          act_n,
  output logic [cfg_pkg::T_W-1:0] act_t,
  output logic                    ser_owned
);
  import cfg_pkg::*;

  cfg_mode_e      mode_q, mode_d;
  logic           xfer_prev_q;
  logic           xfer_rise, xfer_fall;
  logic [M_W-1:0] held_m_q, held_m_d;
  logic [N_W-1:0] held_n_q, held_n_d;
  logic [T_W-1:0] held_t_q, held_t_d;

  always_comb begin
    xfer_rise = xfer_s & ~xfer_prev_q;
    xfer_fall = ~xfer_s & xfer_prev_q;
    mode_d    = mode_q;
    held_m_d  = held_m_q;
    held_n_d  = held_n_q;
    held_t_d  = held_t_q;
    if (!hold_s) begin
      mode_d = MODE_PAR_LIVE;
    end else begin
      case (mode_q)
        MODE_PAR_LIVE: begin
          held_m_d = pin_m;
          held_n_d = pin_n;
          mode_d   = xfer_rise ? MODE_SER_LIVE : MODE_PAR_HELD;
        end
        MODE_SER_LIVE: begin
          if (xfer_fall) begin
            held_m_d = sr_m;
            held_n_d = sr_n;
            held_t_d = sr_t;
            mode_d   = MODE_SER_HELD;
          end
        end
        default: begin
          if (xfer_rise) mode_d = MODE_SER_LIVE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_PAR_LIVE;
      xfer_prev_q <= 1'b0;
      held_m_q    <= '0;
      held_n_q    <= '0;
      held_t_q    <= '0;
    end else begin
      mode_q      <= mode_d;
      xfer_prev_q <= xfer_s;
      held_m_q    <= held_m_d;
      held_n_q    <= held_n_d;
      held_t_q    <= held_t_d;
    end
  end

  always_comb begin
    act_m = held_m_q;
    act_n = held_n_q;
    act_t = held_t_q;
    case (mode_q)
      MODE_PAR_LIVE: begin
        act_m = pin_m;
        act_n = pin_n;
      end
      MODE_SER_LIVE: begin
        act_m = sr_m;
        act_n = sr_n;
        act_t = sr_t;
      end
      default: ;
    endcase
  end

  assign ser_owned = (mode_q == MODE_SER_LIVE) || (mode_q == MODE_SER_HELD);

  // R2: two consecutive cycles in the captured parallel state keep the values fixed
  assert_par_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PAR_HELD && $past(mode_q) == MODE_PAR_HELD) |->
      ($stable(act_m) && $stable(act_n)));

  // R3: a low strobe hands ownership back to the pins
  assert_par_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_s |=> (mode_q == MODE_PAR_LIVE));

  // R6: the falling transfer strobe latches the frame fields
  assert_ser_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SER_LIVE && hold_s && xfer_fall) |=>
      (act_m == $past(sr_m)) && (act_n == $past(sr_n)) && (act_t == $past(sr_t)));
endmodule

// File: rtl/cfg_test_mux.sv
module cfg_test_mux (
  input  logic                    sel_valid,
  input  logic [cfg_pkg::T_W-1:0] sel,
  input  logic                    clear_s,
  input  logic                    ser_bit,
  input  logic                    tap_fb,
  input  logic                    tap_out,
  output logic                    test_o
);
  import cfg_pkg::*;

  logic pick;

  always_comb begin
    case (test_sel_e'(sel))
      TSEL_SER: pick = ser_bit;
      TSEL_FB:  pick = tap_fb & ~clear_s;
      TSEL_OUT: pick = tap_out & ~clear_s;
      default:  pick = 1'b0;
    endcase
    test_o = sel_valid & pick;
  end
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port #(
  parameter int M_W         = 9,
  parameter int N_W         = 2,
  parameter int NULL_W      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_hold,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_din,
  input  logic           ser_clk,
  input  logic           ser_xfer,
  input  logic           div_clear,
  input  logic           tap_fb,
  input  logic           tap_out,
  output logic [M_W-1:0] act_m,
  output logic [N_W-1:0] act_n,
  output logic [1:0]     act_t,
  output logic           test_o
);
  localparam int T_W    = cfg_pkg::T_W;
  localparam int SYNC_W = 5 + N_W + M_W;

  logic [SYNC_W-1:0] raw_bus, sync_bus;
  logic              hold_s, sclk_s, xfer_s, din_s, clear_s;
  logic [M_W-1:0]    pin_m_s, sr_m;
  logic [N_W-1:0]    pin_n_s, sr_n;
  logic [T_W-1:0]    sr_t, act_t_w;
  logic              sr_head, ser_owned;

  assign raw_bus = {par_hold, ser_clk, ser_xfer, ser_din, div_clear, par_n, par_m};
  assign {hold_s, sclk_s, xfer_s, din_s, clear_s, pin_n_s, pin_m_s} = sync_bus;

  cfg_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus));

  cfg_shift #(.M_W(M_W), .N_W(N_W), .NULL_W(NULL_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .din_s(din_s), .shift_en(hold_s),
    .sr_m(sr_m), .sr_n(sr_n), .sr_t(sr_t), .sr_head(sr_head));

  cfg_ctrl #(.M_W(M_W), .N_W(N_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hold_s(hold_s), .xfer_s(xfer_s),
    .pin_m(pin_m_s), .pin_n(pin_n_s), .sr_m(sr_m), .sr_n(sr_n), .sr_t(sr_t),
    .act_m(act_m), .act_n(act_n), .act_t(act_t_w), .ser_owned(ser_owned));

  cfg_test_mux u_mux (
    .sel_valid(ser_owned), .sel(act_t_w), .clear_s(clear_s), .ser_bit(sr_head),
    .tap_fb(tap_fb), .tap_out(tap_out), .test_o(test_o));

  assign act_t = act_t_w;

  // R9: TEST is quiet whenever the parallel path owns the values
  assert_test_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_owned |-> !test_o);

  // R8: select code 00 always yields a low TEST
  assert_test_low_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_t == 2'b00) |-> !test_o);

  // R10: while clear is high, the tap selections cannot drive TEST high
  assert_clear_masks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_s && act_t[1]) |-> !test_o);
endmodule

// File: tb/test_synth_cfg_port.sv
module test_synth_cfg_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       par_hold = 1'b0;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic       ser_din = 1'b0, ser_clk = 1'b0, ser_xfer = 1'b0, div_clear = 1'b0;
  logic       tap_fb = 1'b0, tap_out = 1'b0;
  logic [8:0] act_m;
  logic [1:0] act_n, act_t;
  logic       test_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [13:0] model_sr = '0;

  always #2.5 clk = ~clk;

  synth_cfg_port i_synth_cfg_port (
    .clk(clk), .rst_n(rst_n), .par_hold(par_hold), .par_m(par_m), .par_n(par_n),
    .ser_din(ser_din), .ser_clk(ser_clk), .ser_xfer(ser_xfer), .div_clear(div_clear),
    .tap_fb(tap_fb), .tap_out(tap_out), .act_m(act_m), .act_n(act_n), .act_t(act_t),
    .test_o(test_o));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] cfg_of(input logic [1:0] t, input logic [1:0] n, input logic [8:0] m);
    return {t, n, m};
  endfunction

  function automatic logic exp_test(input logic [1:0] t, input logic head);
    case (t)
      2'd1:    return head;
      2'd2:    return tap_fb & ~div_clear;
      2'd3:    return tap_out & ~div_clear;
      default: return 1'b0;
    endcase
  endfunction

  task automatic send_bit(input logic b);
    ser_din = b; tick(3);
    ser_clk = 1'b1; tick(3);
    ser_clk = 1'b0; tick(3);
    if (par_hold) model_sr = {model_sr[12:0], b};
  endtask

  task automatic send_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) send_bit(f[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [12:0] held;
    logic [1:0]  ht;
    // R11: reset with strobe low, values follow pins, select cleared
    par_m = 9'd25; par_n = 2'd2;
    tick(4); rst_n = 1'b1; tick(6);
    check("R11 reset cfg", {3'b0, act_t, act_n, act_m}, {3'b0, cfg_of(2'd0, 2'd2, 9'd25)});
    check("R11 reset test", {15'b0, test_o}, 16'd0);

    // R1 R2 R3: full sweep of feedback values through the parallel path
    ht = 2'd0;
    for (int m = 0; m < 512; m++) begin
      logic [8:0] mv; logic [1:0] nv;
      mv = 9'(m); nv = 2'(m * 3);
      par_m = mv; par_n = nv; tick(5);
      check("R1 follow", {3'b0, act_t, act_n, act_m}, {3'b0, cfg_of(ht, nv, mv)});
      par_hold = 1'b1; tick(5);
      par_m = ~mv; par_n = ~nv; tick(5);
      check("R2 captured", {3'b0, act_t, act_n, act_m}, {3'b0, cfg_of(ht, nv, mv)});
      par_hold = 1'b0; tick(5);
      check("R3 release", {3'b0, act_t, act_n, act_m}, {3'b0, cfg_of(ht, ~nv, ~mv)});
    end

    // R4 R5 R6 R7 R8: serial frames over parallel captured values
    for (int k = 0; k < 40; k++) begin
      logic [8:0] fm; logic [1:0] fn, ft; logic [13:0] fr; logic b;
      fm = 9'((k * 37 + 10) % 512); fn = 2'(k); ft = 2'(k >> 2);
      fr = {ft, k[1] ^ k[3], fn, fm};
      tap_fb = k[0]; tap_out = ~k[0];
      par_m = 9'(k * 5); par_n = 2'(k + 1); tick(4);
      par_hold = 1'b1; tick(5);
      held = cfg_of(act_t, 2'(k + 1), 9'(k * 5));
      send_frame(fr);
      check("R7 pre-transfer", {3'b0, act_t, act_n, act_m}, {3'b0, held});
      ser_xfer = 1'b1; tick(5);
      check("R4 R5 frame", {3'b0, act_t, act_n, act_m}, {3'b0, cfg_of(ft, fn, fm)});
      check("R8 test live", {15'b0, test_o}, {15'b0, exp_test(ft, model_sr[0])});
      b = k[2];
      send_bit(b); tick(2);
      check("R5 live shift", {3'b0, act_t, act_n, act_m},
            {3'b0, model_sr[13:12], model_sr[10:9], model_sr[8:0]});
      ser_xfer = 1'b0; tick(5);
      held = {model_sr[13:12], model_sr[10:9], model_sr[8:0]};
      send_bit(~b); tick(2);
      check("R6 latched", {3'b0, act_t, act_n, act_m}, {3'b0, held});
      check("R8 test held", {15'b0, test_o}, {15'b0, exp_test(held[12:11], model_sr[0])});
      par_hold = 1'b0; tick(5);
    end

    // R9: stale select 11 must not reach TEST in parallel mode
    par_hold = 1'b1; tick(5);
    tap_out = 1'b1;
    send_frame({2'd3, 1'b0, 2'd1, 9'd300});
    ser_xfer = 1'b1; tick(5); ser_xfer = 1'b0; tick(5);
    check("R8 sel 11", {15'b0, test_o}, 16'd1);
    par_hold = 1'b0; tick(5);
    check("R9 quiet", {15'b0, test_o}, 16'd0);
    check("R9 sel kept", {14'b0, act_t}, 16'd3);

    // R10: clear masks taps only
    par_hold = 1'b1; tick(5);
    tap_fb = 1'b1;
    send_frame({2'd2, 1'b1, 2'd3, 9'd17});
    ser_xfer = 1'b1; tick(5); ser_xfer = 1'b0; tick(5);
    check("R10 tap on", {15'b0, test_o}, 16'd1);
    div_clear = 1'b1; tick(5);
    check("R10 masked", {15'b0, test_o}, 16'd0);
    check("R10 cfg kept", {3'b0, act_t, act_n, act_m}, {3'b0, cfg_of(2'd2, 2'd3, 9'd17)});
    div_clear = 1'b0; tick(5);
    check("R10 unmasked", {15'b0, test_o}, 16'd1);

    // R12: clocks while parallel mode is active do not disturb the frame
    par_hold = 1'b0; par_m = 9'd99; par_n = 2'd0; tick(5);
    send_frame({2'd1, 1'b0, 2'd2, 9'd444});
    check("R12 pins live", {3'b0, act_n, act_m}, {3'b0, 2'd0, 9'd99});
    par_hold = 1'b1; tick(5);
    ser_xfer = 1'b1; tick(5);
    check("R12 frame kept", {3'b0, act_t, act_n, act_m}, {3'b0, cfg_of(2'd2, 2'd3, 9'd17)});
    ser_xfer = 1'b0; tick(5);

    // R11: reset with strobe high captures the pins
    rst_n = 1'b0; par_hold = 1'b1; par_m = 9'd28; par_n = 2'd1; tick(4);
    rst_n = 1'b1; tick(6);
    par_m = 9'd10; par_n = 2'd3; tick(6);
    check("R11 captured at release", {3'b0, act_t, act_n, act_m}, {3'b0, cfg_of(2'd0, 2'd1, 9'd28)});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule